// File: doc/BRIEF.md
# Dual-Mode Multiplexed Processor Bus Bridge

This block sits between an on-chip 8-bit processor core and the external memory pins, and it also feeds a shared internal bus that the rest of the chip's peripherals decode. It runs in one of two modes, which a static select input fixes while reset is held. In normal mode the on-chip core owns the internal bus. The core's address, write data and read/write flag go out on the pins, and read data comes back in on the data pins.

In emulation mode the on-chip core is switched off and an external host processor owns the internal bus. The host places the low address byte and the data byte on the same eight data pins, one after the other. An address strobe input opens a transparent latch, and the low address byte is held when the strobe falls. The host drives the middle address bits, the two top address bits and the read/write line in directly. No pin other than the low address byte is driven out in this mode. The two top internal address bits are always passed on to the bank-extension logic.

Top module: `mxb_bus_bridge`

## Requirements
- R1: The mode (0 = normal, 1 = emulation) is taken from `emu_sel_i` on every rising clock edge while `rst_n` is low. After reset is released it does not change, whatever `emu_sel_i` does. `core_dis_o` shows the held mode.
- R2: In normal mode, `ibus_addr_o`, `ibus_rnw_o`, `pin_amid_o` (core address bits 13:8) and `pin_rnw_o` follow the core's address and read/write inputs. `pin_amid_oe` and `pin_rnw_oe` are 1.
- R3: `pin_dat_oe` is 1 only in normal mode with `core_rnw_i` = 0 (a write). When it is 1, `pin_dat_o` equals `core_wdata_i`, and so does `ibus_data_o`.
- R4: In normal mode with `core_rnw_i` = 1, `core_rdata_o` and `ibus_data_o` equal `pin_dat_i`. In emulation mode `core_rdata_o` is 0.
- R5: In emulation mode, `core_dis_o` is 1 and `pin_dat_oe`, `pin_amid_oe` and `pin_rnw_oe` are all 0.
- R6: In emulation mode, `ibus_addr_o[7:0]` follows `pin_dat_i` while `pin_strobe_i` is 1. After the strobe falls it holds the last value seen, even when `pin_dat_i` changes.
- R7: In emulation mode, `ibus_addr_o[15:8]` equals `{pin_ahi_i, pin_amid_i}`, `ibus_rnw_o` equals `pin_rnw_i`, and `ibus_data_o` equals `pin_dat_i`.
- R8: `pin_alo_o` equals `ibus_addr_o[7:0]` in both modes.
- R9: In normal mode, `pin_strobe_i` has no effect. The low address stays the core's, and a byte presented with the strobe high is not captured. After a later reset into emulation with the strobe low, the low address still shows the byte last captured in emulation.
- R10: `bank_ahi_o` equals `ibus_addr_o[15:14]`. In normal mode this is core address bits 15:14, and in emulation mode it is `pin_ahi_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the mode is loaded while it is low |
| emu_sel_i | input | 1 | Static mode select: 1 = emulation |
| core_addr_i | input | 16 | On-chip core address |
| core_wdata_i | input | 8 | On-chip core write data |
| core_rnw_i | input | 1 | On-chip core read/not-write |
| core_rdata_o | output | 8 | Read data returned to the core |
| core_dis_o | output | 1 | Core drivers disabled (emulation mode) |
| ibus_addr_o | output | 16 | Internal address bus |
| ibus_data_o | output | 8 | Internal data bus |
| ibus_rnw_o | output | 1 | Internal read/not-write |
| bank_ahi_o | output | 2 | Top two address bits sent to the bank logic |
| pin_dat_i | input | 8 | Data pins, input side |
| pin_dat_o | output | 8 | Data pins, output value |
| pin_dat_oe | output | 1 | Data pins output enable |
| pin_strobe_i | input | 1 | Address strobe from the host |
| pin_alo_o | output | 8 | Low address byte pins (always output) |
| pin_amid_i | input | 6 | Address bits 13:8 from the host |
| pin_amid_o | output | 6 | Address bits 13:8 from the core |
| pin_amid_oe | output | 1 | Address bits 13:8 output enable |
| pin_ahi_i | input | 2 | Address bits 15:14 from the host |
| pin_rnw_i | input | 1 | Read/not-write from the host |
| pin_rnw_o | output | 1 | Read/not-write from the core |
| pin_rnw_oe | output | 1 | Read/not-write output enable |

## Verification
The assertions are checked on every clock. They cover these points: the mode stays fixed once reset is released; no pin driver is enabled in emulation mode; the data driver is never on during a read; the latched low byte holds while the strobe stays low; and the bank bits track the host pins in emulation. Other behaviour can only be shown by the bench's scenarios. The first is the demultiplexing order, where the strobe rises, falls, and then the data byte replaces the address on the same pins. The second is that strobe activity in normal mode leaves no trace, which the bench sees only after a fresh reset into emulation mode. A per-cycle reference model in the bench compares every output in both modes.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic {MODE_NORMAL = 1'b0, MODE_EMUL = 1'b1} bus_mode_e;

  // the data pins are driven only for a core write in normal mode
  function automatic logic dat_drive(input bus_mode_e m, input logic rnw);
    return (m == MODE_NORMAL) && !rnw;
  endfunction

  // 2:1 choice between a core-derived and a host-derived value
  function automatic logic [15:0] pick16(input bus_mode_e m, input logic [15:0] core_v,
                                         input logic [15:0] host_v);
    return (m == MODE_EMUL) ? host_v : core_v;
  endfunction
endpackage

// File: rtl/mxb_mode_reg.sv
module mxb_mode_reg
  import mxb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_i,
  output bus_mode_e mode_o
);
  bus_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= sel_i ? MODE_EMUL : MODE_NORMAL;
  end

  assign mode_o = mode_q;

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/mxb_alo_latch.sv
module mxb_alo_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         emu_i,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic         open_w;
  logic [W-1:0] lat_q;

  assign open_w = emu_i && strobe_i;

  always_latch begin
    if (open_w) lat_q = d_i;
  end

  assign q_o = lat_q;

  // R6
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_i && !strobe_i && $past(emu_i && !strobe_i && rst_n)) |-> $stable(q_o));
endmodule

// File: rtl/mxb_route.sv
module mxb_route
  import mxb_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int HI_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bus_mode_e             mode_i,
  input  logic [AW-1:0]         core_addr_i,
  input  logic [DW-1:0]         core_wdata_i,
  input  logic                  core_rnw_i,
  input  logic [DW-1:0]         lat_lo_i,
  input  logic [AW-DW-HI_W-1:0] host_mid_i,
  input  logic [HI_W-1:0]       host_hi_i,
  input  logic                  host_rnw_i,
  input  logic [DW-1:0]         pin_dat_i,
  output logic [AW-1:0]         ibus_addr_o,
  output logic [DW-1:0]         ibus_data_o,
  output logic                  ibus_rnw_o,
  output logic [DW-1:0]         core_rdata_o,
  output logic                  dat_oe_o,
  output logic                  ctl_oe_o
);
  localparam int MID_W = AW - DW - HI_W;

  logic          emu_w;
  logic [AW-1:0] host_addr_w;
  logic [DW-1:0] norm_data_w;

  assign emu_w       = (mode_i == MODE_EMUL);
  assign host_addr_w = {host_hi_i, host_mid_i, lat_lo_i};
  assign ibus_addr_o = pick16(mode_i, core_addr_i, host_addr_w);
  assign norm_data_w = core_rnw_i ? pin_dat_i : core_wdata_i;
  assign ibus_data_o = emu_w ? pin_dat_i : norm_data_w;
  assign ibus_rnw_o  = emu_w ? host_rnw_i : core_rnw_i;
  assign core_rdata_o = emu_w ? '0 : pin_dat_i;
  assign dat_oe_o    = dat_drive(mode_i, core_rnw_i);
  assign ctl_oe_o    = !emu_w;

  // R5
  emu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu_w |-> (!dat_oe_o && !ctl_oe_o));
  // R3
  dat_oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe_o |-> (!core_rnw_i && ibus_data_o == core_wdata_i));
  // R10
  bank_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu_w |-> (ibus_addr_o[AW-1 -: HI_W] == host_hi_i));
  // R7
  host_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu_w |-> (ibus_addr_o[DW +: MID_W] == host_mid_i && ibus_rnw_o == host_rnw_i));
endmodule

// File: rtl/mxb_bus_bridge.sv
module mxb_bus_bridge
  import mxb_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int HI_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  emu_sel_i,
  input  logic [AW-1:0]         core_addr_i,
  input  logic [DW-1:0]         core_wdata_i,
  input  logic                  core_rnw_i,
  output logic [DW-1:0]         core_rdata_o,
  output logic                  core_dis_o,
  output logic [AW-1:0]         ibus_addr_o,
  output logic [DW-1:0]         ibus_data_o,
  output logic                  ibus_rnw_o,
  output logic [HI_W-1:0]       bank_ahi_o,
  input  logic [DW-1:0]         pin_dat_i,
  output logic [DW-1:0]         pin_dat_o,
  output logic                  pin_dat_oe,
  input  logic                  pin_strobe_i,
  output logic [DW-1:0]         pin_alo_o,
  input  logic [AW-DW-HI_W-1:0] pin_amid_i,
  output logic [AW-DW-HI_W-1:0] pin_amid_o,
  output logic                  pin_amid_oe,
  input  logic [HI_W-1:0]       pin_ahi_i,
  input  logic                  pin_rnw_i,
  output logic                  pin_rnw_o,
  output logic                  pin_rnw_oe
);
  localparam int MID_W = AW - DW - HI_W;

  bus_mode_e     mode_w;
  logic          emu_w;
  logic [DW-1:0] lat_lo_w;
  logic          ctl_oe_w;

  mxb_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .sel_i(emu_sel_i), .mode_o(mode_w)
  );

  assign emu_w = (mode_w == MODE_EMUL);

  mxb_alo_latch #(.W(DW)) u_lat (
    .clk(clk), .rst_n(rst_n), .emu_i(emu_w), .strobe_i(pin_strobe_i),
    .d_i(pin_dat_i), .q_o(lat_lo_w)
  );

  mxb_route #(.AW(AW), .DW(DW), .HI_W(HI_W)) u_route (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_w),
    .core_addr_i(core_addr_i), .core_wdata_i(core_wdata_i), .core_rnw_i(core_rnw_i),
    .lat_lo_i(lat_lo_w), .host_mid_i(pin_amid_i), .host_hi_i(pin_ahi_i),
    .host_rnw_i(pin_rnw_i), .pin_dat_i(pin_dat_i),
    .ibus_addr_o(ibus_addr_o), .ibus_data_o(ibus_data_o), .ibus_rnw_o(ibus_rnw_o),
    .core_rdata_o(core_rdata_o), .dat_oe_o(pin_dat_oe), .ctl_oe_o(ctl_oe_w)
  );

  assign core_dis_o  = emu_w;
  assign bank_ahi_o  = ibus_addr_o[AW-1 -: HI_W];
  assign pin_alo_o   = ibus_addr_o[DW-1:0];
  assign pin_dat_o   = core_wdata_i;
  assign pin_amid_o  = core_addr_i[DW +: MID_W];
  assign pin_amid_oe = ctl_oe_w;
  assign pin_rnw_o   = core_rnw_i;
  assign pin_rnw_oe  = ctl_oe_w;

  // R9
  strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emu_w |-> (pin_alo_o == core_addr_i[DW-1:0]));
endmodule

// File: tb/sim_mxb_bus_bridge.sv
module sim_mxb_bus_bridge;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, emu_sel = 0;
  logic [15:0] core_addr = 0; logic [7:0] core_wdata = 0; logic core_rnw = 1;
  logic [7:0] core_rdata; logic core_dis;
  logic [15:0] ibus_addr; logic [7:0] ibus_data; logic ibus_rnw; logic [1:0] bank_ahi;
  logic [7:0] dat_i = 0, dat_o; logic dat_oe, strobe = 0;
  logic [7:0] alo; logic [5:0] amid_i = 0, amid_o; logic amid_oe;
  logic [1:0] ahi = 0; logic rnw_i = 1, rnw_o, rnw_oe;

  int checks = 0, fails = 0; bit done = 0;
  bit m_emu = 0; logic [7:0] m_lat = 0; bit m_lat_ok = 0;

  mxb_bus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .emu_sel_i(emu_sel),
    .core_addr_i(core_addr), .core_wdata_i(core_wdata), .core_rnw_i(core_rnw),
    .core_rdata_o(core_rdata), .core_dis_o(core_dis),
    .ibus_addr_o(ibus_addr), .ibus_data_o(ibus_data), .ibus_rnw_o(ibus_rnw),
    .bank_ahi_o(bank_ahi), .pin_dat_i(dat_i), .pin_dat_o(dat_o), .pin_dat_oe(dat_oe),
    .pin_strobe_i(strobe), .pin_alo_o(alo), .pin_amid_i(amid_i), .pin_amid_o(amid_o),
    .pin_amid_oe(amid_oe), .pin_ahi_i(ahi), .pin_rnw_i(rnw_i), .pin_rnw_o(rnw_o),
    .pin_rnw_oe(rnw_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // reference mode: loaded while reset is low
  always @(posedge clk) if (!rst_n) m_emu = emu_sel;

  // per-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] ea; logic [7:0] ed; logic er;
      if (m_emu && strobe) begin m_lat = dat_i; m_lat_ok = 1; end
      ea = m_emu ? {ahi, amid_i, m_lat} : core_addr;
      ed = m_emu ? dat_i : (core_rnw ? dat_i : core_wdata);
      er = m_emu ? rnw_i : core_rnw;
      chk("R1 core_dis", core_dis, m_emu);
      if (!m_emu || m_lat_ok) begin
        chk(m_emu ? "R6 ibus_addr_lo" : "R2 ibus_addr_lo", ibus_addr[7:0], ea[7:0]);
        chk("R8 pin_alo", alo, ea[7:0]);
      end
      chk(m_emu ? "R7 ibus_addr_hi" : "R2 ibus_addr_hi", ibus_addr[15:8], ea[15:8]);
      chk(m_emu ? "R7 ibus_data" : "R4 ibus_data", ibus_data, ed);
      chk(m_emu ? "R7 ibus_rnw" : "R2 ibus_rnw", ibus_rnw, er);
      chk("R10 bank_ahi", bank_ahi, ea[15:14]);
      chk("R3 dat_oe", dat_oe, !m_emu && !core_rnw);
      chk("R5 amid_oe", amid_oe, !m_emu);
      chk("R5 rnw_oe", rnw_oe, !m_emu);
      chk("R4 core_rdata", core_rdata, m_emu ? 8'h00 : dat_i);
      if (!m_emu) begin
        chk("R2 pin_amid_o", amid_o, core_addr[13:8]);
        chk("R2 pin_rnw_o", rnw_o, core_rnw);
        if (!core_rnw) chk("R3 pin_dat_o", dat_o, core_wdata);
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  task automatic do_reset(input bit emu);
    rst_n = 0; emu_sel = emu; strobe = 0; step(3); rst_n = 1; step(1);
  endtask

  task automatic host_cycle(input logic [15:0] a, input logic [7:0] d, input bit rw);
    amid_i = a[13:8]; ahi = a[15:14]; rnw_i = rw;
    dat_i = a[7:0]; strobe = 1; step(1);
    strobe = 0; step(1);
    dat_i = d; step(1);
    #2 chk("R6 addr held after data", ibus_addr[7:0], a[7:0]);
    chk("R7 data on ibus", ibus_data, d);
    step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1; step(1);
    // reset state in normal mode
    chk("R1 reset normal", core_dis, 0);
    chk("R5 reset amid_oe", amid_oe, 1);

    // normal-mode traffic with strobe toggling (R2 R3 R4 R9)
    for (int i = 0; i < 16; i++) begin
      core_addr = 16'h0101 + i * 16'h2345;
      core_rnw = i[0];
      core_wdata = 8'(i * 37 + 5);
      dat_i = ~core_wdata;
      strobe = i[1];
      step(1);
    end

    // R1: select changes after reset have no effect
    emu_sel = 1; step(4);
    chk("R1 mode held", core_dis, 0);

    // emulation mode
    do_reset(1);
    chk("R5 core_dis emul", core_dis, 1);
    host_cycle(16'hC35A, 8'h9E, 1);
    host_cycle(16'h7F01, 8'h44, 0);
    host_cycle(16'h00FF, 8'h11, 1);
    host_cycle(16'hBEEF, 8'hA5, 0);
    host_cycle(16'h5AA5, 8'h3C, 1);

    // R9: strobe in normal mode leaves latch untouched
    host_cycle(16'h125A, 8'h00, 1);
    do_reset(0);
    core_addr = 16'h4321; core_rnw = 1;
    dat_i = 8'hC3; strobe = 1; step(2);
    chk("R9 normal low addr", alo, 8'h21);
    strobe = 0; step(1);
    dat_i = 8'h77;
    do_reset(1);
    m_lat = 8'h5A;
    chk("R9 latch unchanged", ibus_addr[7:0], 8'h5A);
    chk("R10 bank emul", bank_ahi, ahi);
    step(2);
    summary();
  end
endmodule